// File: doc/BRIEF.md
# Live-Layer Reveal Sequencer

This block supervises a video capture front end and the live-picture layer of an output compositor. On a programmable poll tick it decides whether the incoming picture is trustworthy. A poll counts as stable only when the capture side reports lock and the resolution and colour space match the previous poll. When the picture becomes untrustworthy, the block stops capture and hides the live layer. The compositor keeps running, so the screen still shows background and overlay only.

When stability comes back, the block records the current value of the frame-buffer read counter. It raises a reconfigure request and holds it until the request is acknowledged. Capture restarts in the cycle after the acknowledge. The live layer is revealed only once the read counter has moved on by `REVEAL_FRAMES` (default four) from the recorded value, so frames left over from before the disturbance drain first. A change on the output side also hides the layer and starts a fresh drain count from the counter value at that moment.

Top module: `vls_sequencer`

## Requirements
- R1: After reset, and after any later reset, `capture_en`, `layer_en` and `reconf_req` are all 0.
- R2: A poll happens once every `poll_interval` cycles (0 and 1 both mean every cycle). A poll is stable only if `lock_in` is 1 and `in_width`, `in_height` and `in_cspace` all equal the values taken at the previous poll. Between polls the stability verdict does not change.
- R3: Once a poll is unstable, `capture_en` and `layer_en` are both 0 from the next cycle on, and they stay 0 while polls remain unstable.
- R4: When a stable poll follows an unstable one, `reconf_req` rises. It stays 1 until `reconf_ack` is seen, and `capture_en` stays 0 during that time.
- R5: `capture_en` becomes 1 in the cycle after the cycle in which `reconf_ack` is 1 while a request is pending, and `reconf_req` drops in the same cycle.
- R6: `layer_en` rises only after `frame_rd_count` has advanced by at least `REVEAL_FRAMES` (4) from the value recorded when stability returned. It rises one cycle after the counter reaches that value.
- R7: The advance is computed modulo 2^16, so a wrap of the counter from 0xFFFF to 0x0000 counts as one frame.
- R8: A one-cycle `out_change` pulse while capture is running clears `layer_en` in the next cycle. The drain count then restarts from the counter value in the pulse cycle.
- R9: If stability is lost during the drain wait, the wait is abandoned and the layer stays hidden. After recovery the full count of 4 starts again from the counter value at recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_interval | input | 16 | Cycles between stability polls |
| lock_in | input | 1 | Capture unit reports lock |
| in_width | input | 14 | Current input width |
| in_height | input | 14 | Current input height |
| in_cspace | input | 2 | Current input colour-space code |
| out_change | input | 1 | One-cycle pulse on an output hot-plug or format change |
| frame_rd_count | input | 16 | Running count of frames read from the frame buffer |
| reconf_ack | input | 1 | Acknowledge of the reconfigure request |
| capture_en | output | 1 | Capture unit may forward video |
| reconf_req | output | 1 | Request to reconfigure for the new format |
| layer_en | output | 1 | Compositor live-video layer visible |

## Verification
The results fall due at different times. The poll tick is registered, so a stability verdict lands one cycle after the tick. Capture, layer and request outputs follow the verdict one cycle later. `capture_en` follows an acknowledge one cycle later, and `layer_en` follows the counter reaching its target one cycle later. The bench drives inputs on the falling edge and samples on the falling edge. For each exact-cycle result it therefore checks at the first falling edge after the register update, as with the acknowledge and the frame-count thresholds. For poll-dependent results it waits a settle window several poll periods long before sampling. The poll-rate test uses a 40-cycle interval and checks that the request is still low at cycle 60 after reset and high by cycle 100, the second poll being the first that can be stable.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    SQ_DOWN   = 2'd0,
    SQ_RECONF = 2'd1,
    SQ_WAIT   = 2'd2,
    SQ_LIVE   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/vls_poll_timer.sv
module vls_poll_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] interval,
  output logic              tick
);
  logic [TICK_W-1:0] cnt;
  logic [TICK_W:0]   nxt;

  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (nxt >= {1'b0, interval}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= nxt[TICK_W-1:0];
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/vls_stability.sv
module vls_stability #(
  parameter int RES_W = 14,
  parameter int CS_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lock_in,
  input  logic [RES_W-1:0] width,
  input  logic [RES_W-1:0] height,
  input  logic [CS_W-1:0]  cspace,
  output logic             stable
);
  localparam int FMT_W = 2 * RES_W + CS_W;
  logic [FMT_W-1:0] fmt_now, fmt_prev;

  assign fmt_now = {width, height, cspace};

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_prev <= '0;
      stable   <= 1'b0;
    end else if (tick) begin
      fmt_prev <= fmt_now;
      stable   <= lock_in && (fmt_now == fmt_prev);
    end
  end

  // R2
  verdict_between_polls_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stable));
endmodule

// File: rtl/vls_frame_gate.sv
module vls_frame_gate #(
  parameter int FC_W   = 16,
  parameter int FRAMES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [FC_W-1:0] count,
  output logic            reached
);
  localparam logic [FC_W-1:0] TARGET = FC_W'(FRAMES);
  logic [FC_W-1:0] base, advance;

  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= count;
  end

  // modular distance handles counter wrap
  assign advance = count - base;
  assign reached = (advance >= TARGET);
endmodule

// File: rtl/vls_sequencer.sv
module vls_sequencer #(
  parameter int TICK_W        = 16,
  parameter int RES_W         = 14,
  parameter int CS_W          = 2,
  parameter int FC_W          = 16,
  parameter int REVEAL_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] poll_interval,
  input  logic              lock_in,
  input  logic [RES_W-1:0]  in_width,
  input  logic [RES_W-1:0]  in_height,
  input  logic [CS_W-1:0]   in_cspace,
  input  logic              out_change,
  input  logic [FC_W-1:0]   frame_rd_count,
  input  logic              reconf_ack,
  output logic              capture_en,
  output logic              reconf_req,
  output logic              layer_en
);
  import vls_pkg::*;

  logic       tick, stable_q, reached, load_base;
  seq_state_t state;

  vls_poll_timer #(.TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst(rst), .interval(poll_interval), .tick(tick)
  );

  vls_stability #(.RES_W(RES_W), .CS_W(CS_W)) u_stab (
    .clk(clk), .rst(rst), .tick(tick), .lock_in(lock_in),
    .width(in_width), .height(in_height), .cspace(in_cspace),
    .stable(stable_q)
  );

  assign load_base = stable_q && ((state == SQ_DOWN) || out_change);

  vls_frame_gate #(.FC_W(FC_W), .FRAMES(REVEAL_FRAMES)) u_gate (
    .clk(clk), .rst(rst), .load(load_base), .count(frame_rd_count),
    .reached(reached)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_DOWN;
      capture_en <= 1'b0;
      layer_en   <= 1'b0;
      reconf_req <= 1'b0;
    end else begin
      case (state)
        SQ_DOWN: begin
          if (stable_q) begin
            state      <= SQ_RECONF;
            reconf_req <= 1'b1;
          end
        end
        SQ_RECONF: begin
          if (!stable_q) begin
            state      <= SQ_DOWN;
            reconf_req <= 1'b0;
          end else if (reconf_ack) begin
            state      <= SQ_WAIT;
            reconf_req <= 1'b0;
            capture_en <= 1'b1;
          end
        end
        SQ_WAIT: begin
          if (!stable_q) begin
            state      <= SQ_DOWN;
            capture_en <= 1'b0;
          end else if (!out_change && reached) begin
            state    <= SQ_LIVE;
            layer_en <= 1'b1;
          end
        end
        default: begin
          if (!stable_q) begin
            state      <= SQ_DOWN;
            capture_en <= 1'b0;
            layer_en   <= 1'b0;
          end else if (out_change) begin
            state    <= SQ_WAIT;
            layer_en <= 1'b0;
          end
        end
      endcase
    end
  end

  // R3
  unstable_hides_chk: assert property (@(posedge clk) disable iff (rst)
    !stable_q |=> (!layer_en && !capture_en));
  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && !reconf_ack && stable_q) |=> reconf_req);
  // R5
  capture_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(capture_en) |-> $past(reconf_ack));
  // R6
  layer_needs_capture_chk: assert property (@(posedge clk) disable iff (rst)
    layer_en |-> capture_en);
  // R8
  out_change_hides_chk: assert property (@(posedge clk) disable iff (rst)
    out_change |=> !layer_en);
endmodule

// File: tb/vls_sequencer_test.sv
module vls_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] poll_interval = 16'd4;
  logic        lock_in = 1'b0;
  logic [13:0] in_width = 14'd1920;
  logic [13:0] in_height = 14'd1080;
  logic [1:0]  in_cspace = 2'd0;
  logic        out_change = 1'b0;
  logic [15:0] frame_ctr = 16'd0;
  logic        reconf_ack = 1'b0;
  logic        capture_en, reconf_req, layer_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vls_sequencer uut (
    .clk(clk), .rst(rst), .poll_interval(poll_interval), .lock_in(lock_in),
    .in_width(in_width), .in_height(in_height), .in_cspace(in_cspace),
    .out_change(out_change), .frame_rd_count(frame_ctr),
    .reconf_ack(reconf_ack), .capture_en(capture_en),
    .reconf_req(reconf_req), .layer_en(layer_en)
  );

  // vector fields: lock, fmt_sel[1:0], frames[2:0], oc, exp_cap, exp_layer
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0},  // R2 R4 R5 bring-up
    {1'b1, 2'd0, 3'd3, 1'b0, 1'b1, 1'b0},  // R6 three frames: hidden
    {1'b1, 2'd0, 3'd1, 1'b0, 1'b1, 1'b1},  // R6 fourth frame: shown
    {1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0},  // R8 output change
    {1'b1, 2'd0, 3'd4, 1'b0, 1'b1, 1'b1},  // R8 four more frames
    {1'b0, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0},  // R3 lock lost
    {1'b1, 2'd1, 3'd2, 1'b0, 1'b1, 1'b0},  // R6 new format, two frames
    {1'b1, 2'd2, 3'd5, 1'b0, 1'b1, 1'b1}   // R9 format change mid-wait
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic set_fmt(input logic [1:0] sel);
    case (sel)
      2'd0: begin in_width = 14'd1920; in_height = 14'd1080; in_cspace = 2'd0; end
      2'd1: begin in_width = 14'd3840; in_height = 14'd2160; in_cspace = 2'd1; end
      default: begin in_width = 14'd1280; in_height = 14'd720; in_cspace = 2'd2; end
    endcase
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reconf_ack = reconf_req;
    end
    @(negedge clk);
    reconf_ack = 1'b0;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_ctr = frame_ctr + 16'd1;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_oc();
    @(negedge clk);
    out_change = 1'b1;
    @(negedge clk);
    out_change = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset capture", capture_en, 1'b0);
    chk("R1 reset layer", layer_en, 1'b0);
    chk("R1 reset req", reconf_req, 1'b0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      lock_in = VEC[v][8];
      set_fmt(VEC[v][7:6]);
      settle(24);
      if (VEC[v][2]) pulse_oc();
      adv(int'(VEC[v][5:3]));
      chk($sformatf("vector %0d capture (R3/R5)", v), capture_en, VEC[v][1]);
      chk($sformatf("vector %0d layer (R6/R8/R9)", v), layer_en, VEC[v][0]);
      chk($sformatf("vector %0d req idle (R4)", v), reconf_req, 1'b0);
    end

    // R4 R5 R7: held request, capture after ack, counter wrap
    lock_in = 1'b0;
    settle(12);
    chk("R3 down before wrap test", capture_en, 1'b0);
    frame_ctr = 16'hFFFD;
    lock_in = 1'b1;
    for (int i = 0; i < 30 && !reconf_req; i++) @(negedge clk);
    chk("R4 request raised", reconf_req, 1'b1);
    chk("R4 capture off while pending", capture_en, 1'b0);
    repeat (8) @(negedge clk);
    chk("R4 request held without ack", reconf_req, 1'b1);
    reconf_ack = 1'b1;
    @(negedge clk);
    reconf_ack = 1'b0;
    chk("R5 capture one cycle after ack", capture_en, 1'b1);
    chk("R5 request dropped", reconf_req, 1'b0);
    adv(3);
    chk("R7 three frames across wrap: hidden", layer_en, 1'b0);
    adv(1);
    chk("R7 fourth frame after wrap: shown", layer_en, 1'b1);

    // R8 R9: abandon wait on instability, fresh count on recovery
    pulse_oc();
    chk("R8 output change hides layer", layer_en, 1'b0);
    adv(2);
    lock_in = 1'b0;
    settle(12);
    chk("R9 capture off during lost wait", capture_en, 1'b0);
    chk("R9 layer off during lost wait", layer_en, 1'b0);
    lock_in = 1'b1;
    settle(24);
    chk("R9 capture back", capture_en, 1'b1);
    adv(2);
    chk("R9 old wait not resumed", layer_en, 1'b0);
    adv(2);
    chk("R9 fresh four frames shown", layer_en, 1'b1);

    // R1 reset from live, then R2 poll interval of 40
    poll_interval = 16'd40;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset from live capture", capture_en, 1'b0);
    chk("R1 reset from live layer", layer_en, 1'b0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk("R2 no request before second poll", reconf_req, 1'b0);
    repeat (40) @(negedge clk);
    chk("R2 request after second poll", reconf_req, 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule